// File: doc/BRIEF.md
# Memory-Mapped GPIO Line Bank

This block is a bank of general-purpose I/O lines controlled through a small register interface with single-cycle read and write strobes. Each line has an output latch bit and a direction bit. The direction bit drives the line's output enable. The latch bit drives the line's output value. The input pins are brought in through a two-flop synchroniser and can be read back as the data register.

Software changes line levels without a read-modify-write. It writes ones to a set register to raise lines and ones to a clear register to lower them. Built without a clear register, the set register acts instead as a plain latch that takes the whole written word.

Direction can be programmed in two ways. One register takes a 1 per output line. The other takes a 1 per input line. The two always read as exact complements. Two build parameters adapt the bank to the software's view of the bus:
- One mirrors the line-to-bit order.
- The other reverses the byte lanes of the bus on both reads and writes.

Top module: `mmio_gpio_bank`

## Requirements
- R1: After reset every line is an input (`oe_o` all zero), the output latch is zero (`out_o` all zero), and the set and output-direction registers read zero while the input-direction register reads all ones.
- R2: A read at offset 0 returns the pin levels, a 1 meaning the line is high. A pin change becomes visible to a read strobe sampled at the third rising clock edge after the change, because of the two-flop synchroniser.
- R3: With the clear register built (`USE_CLR_REG`=1), a write at offset 1 sets each line whose written bit is 1 and leaves every line whose written bit is 0 unchanged.
- R4: With the clear register built, a write at offset 2 drives low each line whose written bit is 1 and leaves every other line unchanged.
- R5: With `USE_CLR_REG`=0, a write at offset 1 loads the whole word into the latch: a written 1 drives high and a written 0 drives low. Writes at offset 2 then have no effect.
- R6: A write at offset 3 loads the direction state, where 1 means output. A write at offset 4 loads its complement, where 1 means input. `oe_o` equals the direction state.
- R7: Reads at offset 3 and offset 4 always return bitwise complements of each other.
- R8: A read at offset 1 returns the output latch, and `out_o` equals the latch.
- R9: With `MIRROR_BITS`=1, line n corresponds to register bit WIDTH-1-n for every register.
- R10: With `SWAP_BYTES`=1, register byte k appears on bus byte WIDTH/8-1-k on both reads and writes. The build is rejected when `SWAP_BYTES`=1 and WIDTH is 64. WIDTH must be 8, 16, 32 or 64.
- R11: Offsets are 0 data, 1 set, 2 clear, 3 output-direction and 4 input-direction. Reads at offset 2 and at offsets 5 to 7 return zero. Writes at offsets 5 to 7 have no effect.
- R12: `rdata_o` updates on the clock edge that samples `rd_en_i` and holds its value until the next read strobe, whatever writes occur in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 3 | Register offset in register-width units |
| wdata_i | input | WIDTH | Write data, bus lane order |
| rdata_o | output | WIDTH | Read data, registered, bus lane order |
| pin_i | input | WIDTH | Raw input pin levels, line order |
| oe_o | output | WIDTH | Per-line output enable |
| out_o | output | WIDTH | Per-line output value |

## Verification
The bench builds two instances that share one stimulus stream:
- The first uses the defaults: 32 lines, natural bit order, natural byte order and a separate clear register. This build exercises atomic set and clear against a random latch state.
- The second uses 16 lines with mirrored bit order, swapped byte lanes and no clear register. This one build covers line remapping, lane reversal, set-as-latch loading and ignored clear writes.

Hand-computed values for single-byte patterns pin down which bus bit reaches which line.

// File: rtl/mmio_gpio_pkg.sv
package mmio_gpio_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DATA = 3'd0,
    OFF_SET  = 3'd1,
    OFF_CLR  = 3'd2,
    OFF_DOUT = 3'd3,
    OFF_DIN  = 3'd4
  } reg_off_e;

  localparam logic [ADDR_W-1:0] LAST_OFF = 3'd4;
endpackage

// File: rtl/gpio_lane_map.sv
// Static rewiring between bus lane order and line order (an involution).
module gpio_lane_map #(
  parameter int unsigned WIDTH       = 32,
  parameter bit          MIRROR_BITS = 1'b0,
  parameter bit          SWAP_BYTES  = 1'b0
) (
  input  logic [WIDTH-1:0] bus_wr_i,
  output logic [WIDTH-1:0] line_wr_o,
  input  logic [WIDTH-1:0] line_rd_i,
  output logic [WIDTH-1:0] bus_rd_o
);
  localparam int unsigned NBYTES = WIDTH / 8;

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    localparam int unsigned REG_IDX = MIRROR_BITS ? WIDTH - 1 - j : j;
    localparam int unsigned BUS_IDX = SWAP_BYTES
                                      ? (NBYTES - 1 - REG_IDX / 8) * 8 + REG_IDX % 8
                                      : REG_IDX;
    assign line_wr_o[j]      = bus_wr_i[BUS_IDX];
    assign bus_rd_o[BUS_IDX] = line_rd_i[j];
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_line_regs.sv
module gpio_line_regs
  import mmio_gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter bit          USE_CLR_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wline_i,
  output logic [WIDTH-1:0]  latch_o,
  output logic [WIDTH-1:0]  dir_o
);
  logic [WIDTH-1:0] latch_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_SET:  latch_q <= USE_CLR_REG ? (latch_q | wline_i) : wline_i;
        OFF_CLR:  if (USE_CLR_REG) latch_q <= latch_q & ~wline_i;
        OFF_DOUT: dir_q <= wline_i;
        OFF_DIN:  dir_q <= ~wline_i;
        default:  ;
      endcase
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;

  p_set_raises_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (USE_CLR_REG && wr_en_i && addr_i == OFF_SET)
    |=> ((latch_o & $past(wline_i)) == $past(wline_i)));

  p_set_keeps_zero_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (USE_CLR_REG && wr_en_i && addr_i == OFF_SET)
    |=> (((latch_o ^ $past(latch_o)) & ~$past(wline_i)) == '0));

  p_clear_lowers_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (USE_CLR_REG && wr_en_i && addr_i == OFF_CLR)
    |=> ((latch_o & $past(wline_i)) == '0) &&
        (((latch_o ^ $past(latch_o)) & ~$past(wline_i)) == '0));

  p_latch_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!USE_CLR_REG && wr_en_i && addr_i == OFF_SET) |=> (latch_o == $past(wline_i)));

  p_clear_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!USE_CLR_REG && wr_en_i && addr_i == OFF_CLR) |=> $stable(latch_o));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || addr_i > LAST_OFF) |=> ($stable(latch_o) && $stable(dir_o)));
endmodule

// File: rtl/mmio_gpio_bank.sv
module mmio_gpio_bank
  import mmio_gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter bit          MIRROR_BITS = 1'b0,
  parameter bit          SWAP_BYTES  = 1'b0,
  parameter bit          USE_CLR_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  oe_o,
  output logic [WIDTH-1:0]  out_o
);
  if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
    $error("mmio_gpio_bank: WIDTH must be 8, 16, 32 or 64");
  end
  if (SWAP_BYTES && WIDTH == 64) begin : g_bad_swap
    $error("mmio_gpio_bank: byte-lane swap unsupported at 64 bits");
  end

  logic [WIDTH-1:0] wline, rline, rbus, pin_sync, latch, dir;
  logic [WIDTH-1:0] rdata_q;

  gpio_lane_map #(
    .WIDTH(WIDTH), .MIRROR_BITS(MIRROR_BITS), .SWAP_BYTES(SWAP_BYTES)
  ) u_map (
    .bus_wr_i (wdata_i),
    .line_wr_o(wline),
    .line_rd_i(rline),
    .bus_rd_o (rbus)
  );

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (pin_sync)
  );

  gpio_line_regs #(.WIDTH(WIDTH), .USE_CLR_REG(USE_CLR_REG)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wline_i(wline),
    .latch_o(latch),
    .dir_o  (dir)
  );

  always_comb begin
    case (addr_i)
      OFF_DATA: rline = pin_sync;
      OFF_SET:  rline = latch;
      OFF_DOUT: rline = dir;
      OFF_DIN:  rline = ~dir;
      default:  rline = '0;   // clear register is write-only
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rbus;
  end

  assign rdata_o = rdata_q;
  assign oe_o    = dir;
  assign out_o   = latch;

  p_oe_follows_dir_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DOUT) |=> (oe_o == $past(wline)));

  p_oe_follows_din_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIN) |=> (oe_o == ~$past(wline)));

  p_unmapped_read_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i > LAST_OFF || addr_i == OFF_CLR)) |=> (rdata_o == '0));

  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/mmio_gpio_bank_bench.sv
module mmio_gpio_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata_m, oe_m, out_m;
  logic [15:0] rdata_a, oe_a, out_a;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // main build: defaults; alt build: 16 lines, mirrored, swapped, latch mode
  logic [31:0] m_latch = '0, m_dir = '0;
  logic [15:0] a_latch = '0, a_dir = '0;

  always #5 clk = ~clk;

  mmio_gpio_bank u_mmio_gpio_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_m), .pin_i(pins), .oe_o(oe_m), .out_o(out_m)
  );

  mmio_gpio_bank #(.WIDTH(16), .MIRROR_BITS(1'b1), .SWAP_BYTES(1'b1), .USE_CLR_REG(1'b0))
  u_mmio_gpio_bank_alt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata[15:0]), .rdata_o(rdata_a), .pin_i(pins[15:0]), .oe_o(oe_a), .out_o(out_a)
  );

  function automatic logic [15:0] a_to_line(input logic [15:0] bus);
    logic [15:0] r, l;
    r = {bus[7:0], bus[15:8]};
    for (int j = 0; j < 16; j++) l[j] = r[15-j];
    return l;
  endfunction

  function automatic logic [15:0] a_to_bus(input logic [15:0] line);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = line[15-i];
    return {r[7:0], r[15:8]};
  endfunction

  function automatic logic [31:0] exp_m(input logic [2:0] a);
    case (a)
      3'd0: return pins;
      3'd1: return m_latch;
      3'd3: return m_dir;
      3'd4: return ~m_dir;
      default: return '0;
    endcase
  endfunction

  function automatic logic [15:0] exp_a(input logic [2:0] a);
    case (a)
      3'd0: return a_to_bus(pins[15:0]);
      3'd1: return a_to_bus(a_latch);
      3'd3: return a_to_bus(a_dir);
      3'd4: return a_to_bus(~a_dir);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R8";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    logic [15:0] al;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    al = a_to_line(d[15:0]);
    case (a)
      3'd1: begin m_latch = m_latch | d; a_latch = al; end
      3'd2: m_latch = m_latch & ~d;
      3'd3: begin m_dir = d; a_dir = al; end
      3'd4: begin m_dir = ~d; a_dir = ~al; end
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [2:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag_of(a), {32'd0, rdata_m}, {32'd0, exp_m(a)});
    chk({tag_of(a), " R9 R10 alt"}, {48'd0, rdata_a}, {48'd0, exp_a(a)});
  endtask

  task automatic set_pins(input logic [31:0] p);
    @(negedge clk);
    pins = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_lines();
    chk("R6 oe", {32'd0, oe_m}, {32'd0, m_dir});
    chk("R8 out", {32'd0, out_m}, {32'd0, m_latch});
    chk("R9 R10 alt oe", {48'd0, oe_a}, {48'd0, a_dir});
    chk("R5 alt out", {48'd0, out_a}, {48'd0, a_latch});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 oe", {32'd0, oe_m}, 64'd0);
    chk("R1 out", {32'd0, out_m}, 64'd0);
    chk("R1 alt out", {48'd0, out_a}, 64'd0);
    do_read(3'd1);
    do_read(3'd3);
    do_read(3'd4);
    chk("R1 din ones", {32'd0, rdata_m}, {32'd0, 32'hFFFF_FFFF});

    // R3/R5/R9/R10 directed patterns
    do_write(3'd1, 32'h0000_00F0);
    chk("R3 set", {32'd0, out_m}, 64'h0000_00F0);
    chk("R9 R10 mirror+swap", {48'd0, out_a}, 64'h000F);
    do_write(3'd1, 32'h0000_000F);
    chk("R3 set keeps others", {32'd0, out_m}, 64'h0000_00FF);
    chk("R5 latch load", {48'd0, out_a}, 64'h00F0);
    do_write(3'd2, 32'h0000_0030);
    chk("R4 clear", {32'd0, out_m}, 64'h0000_00CF);
    chk("R5 clear ignored", {48'd0, out_a}, 64'h00F0);
    do_write(3'd4, 32'hFFFF_FF00);
    chk("R6 din write", {32'd0, oe_m}, 64'h0000_00FF);
    chk("R10 alt din", {48'd0, oe_a}, 64'h00FF);
    do_read(3'd3);
    chk("R7 dout", {32'd0, rdata_m}, 64'h0000_00FF);
    do_read(3'd4);
    chk("R7 din", {32'd0, rdata_m}, 64'hFFFF_FF00);
    do_write(3'd3, 32'h0000_0001);
    chk("R9 R10 alt single bit", {48'd0, oe_a}, 64'h0080);

    // R2 pins through synchroniser
    set_pins(32'hA5A5_1234);
    do_read(3'd0);
    chk("R2 data", {32'd0, rdata_m}, 64'hA5A5_1234);

    // R11 unmapped
    do_write(3'd6, 32'hFFFF_FFFF);
    chk_lines();
    do_read(3'd7);
    do_read(3'd2);

    // R12 hold
    do_read(3'd1);
    held = rdata_m;
    do_write(3'd1, 32'h1234_5678);
    repeat (3) @(negedge clk);
    chk("R12 hold", {32'd0, rdata_m}, {32'd0, held});

    for (int k = 0; k < 400; k++) begin
      int unsigned op;
      logic [31:0] d;
      op = $urandom % 10;
      d = ($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : $urandom;
      if (op < 4) begin
        do_write(3'($urandom % 8), d);
        chk_lines();
      end else if (op < 8) begin
        do_read(3'($urandom % 8));
      end else begin
        set_pins(d);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule